// File: doc/BRIEF.md
# Segment Translation Unit

This unit turns a segment-relative offset into a 32-bit linear address. It holds a small set of segment slots. Each slot has a hidden cache entry with a base, a limit, a granularity flag, a descriptor privilege level, a code/data flag, a read/write permission flag and the requested privilege level of the value last loaded into it. Loads go through a load port. In real mode a load fills the slot at once, from the 16-bit value shifted left by four. In protected mode the value is treated as a selector. The selector picks the global or the local descriptor table, is bounds-checked against that table's limit, and causes two 32-bit reads of the 8-byte descriptor over a simple memory read port.

Accesses arrive on a separate port with a slot number, an offset and a read/write flag. Each access is checked against the cached entry only; no memory traffic is involved. One cycle later the unit reports the linear address, or a fault together with its kind. While a descriptor fetch is in flight the unit shows busy and drops any load or access that is presented.

Top module: `seg_xlate_unit`

## Requirements
- R1: A load with `prot_mode_i` low fills the slot with base = {12'b0, value, 4'b0} and a limit of 0xFFFF, with privilege 3, data, writable and a requested level of 0. An access to that slot presented in cycle t gives `res_valid_o` and `lin_addr_o` = base + offset in cycle t+1. After reset every slot holds the real-mode entry for value 0.
- R2: In a real-mode slot, an offset above 0xFFFF gives a limit fault (kind 1).
- R3: A protected-mode selector is split as follows: bits [15:3] are the index, bit 2 picks the table (0 = global, 1 = local), and bits [1:0] are the requested level. The descriptor is read at table base + index*8 (low word), then at that address + 4 (high word).
- R4: If index*8+7 exceeds the chosen table's 16-bit limit, `ld_fault_o` pulses in the cycle after the load. No memory read is made and the slot keeps its old contents.
- R5: Descriptor fields are laid out as follows. Low word: limit[15:0] in [15:0] and base[15:0] in [31:16]. High word: base[23:16] in [7:0], read/write permission in bit 9, code flag in bit 11, privilege level in [14:13], limit[19:16] in [19:16], granularity in bit 23 and base[31:24] in [31:24]. `mem_req_o` stays high with a stable address until `mem_rvalid_i`.
- R6: `busy_o` is high from the cycle after a protected load is accepted until the cycle after the second read returns. Loads and accesses presented while busy are ignored.
- R7: The effective limit is the 20-bit limit when granularity is 0 and {limit, 12'hFFF} when it is 1. An offset above the effective limit is a limit fault (kind 1).
- R8: A requested level numerically greater than the descriptor's level is a privilege fault (kind 2).
- R9: The following are rights faults (kind 3): a write to a data slot whose permission bit is 0, any write to a code slot, and a read of a code slot whose permission bit is 0.
- R10: When several faults apply, the kind reported is limit first, then privilege, then rights. `fault_kind_o` is 0 when there is no fault, and `fault_o` is only high with `res_valid_o`.
- R11: The linear address is base + offset modulo 2^32. Accesses never cause memory reads.
- R12: `res_valid_o` is high only in the cycle after an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_mode_i | input | 1 | 1 = loads decode selectors |
| gdt_base_i | input | 32 | Global table base |
| gdt_limit_i | input | 16 | Global table limit (last byte) |
| ldt_base_i | input | 32 | Local table base |
| ldt_limit_i | input | 16 | Local table limit (last byte) |
| ld_valid_i | input | 1 | Load request |
| ld_seg_i | input | SEG_W | Slot to load |
| ld_value_i | input | 16 | Segment value or selector |
| acc_valid_i | input | 1 | Access request |
| acc_seg_i | input | SEG_W | Slot used by the access |
| acc_offset_i | input | 32 | Offset |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Descriptor fetch in flight |
| ld_fault_o | output | 1 | Selector beyond table limit |
| res_valid_o | output | 1 | Access result valid |
| lin_addr_o | output | 32 | Linear address |
| fault_o | output | 1 | Access faulted |
| fault_kind_o | output | 2 | 0 none, 1 limit, 2 privilege, 3 rights |

## Verification
The bench aims at the table-limit boundary. It loads the last index that fits (expecting fetches) and the first index past it (expecting no read and an unchanged slot). A comparison that is off by one would either fetch past the table or reject a valid entry. It also goes after granularity scaling at the exact top offset and one byte beyond, the wrap of base plus offset past 2^32, and accesses that violate several checks at once; wrong scaling would misplace the limit, and a wrong fault priority would report the wrong kind. Finally it presents a load and an access during a fetch. A unit that did not gate on busy would produce an unexpected result or overwrite a slot.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic [1:0]  dpl;
    logic        is_code;
    logic        rw_ok;
    logic [1:0]  rpl;
  } seg_cache_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_RIGHTS = 2'd3
  } fault_kind_e;

  function automatic seg_cache_t real_entry(input logic [15:0] v);
    seg_cache_t e;
    e.base    = {12'b0, v, 4'b0};
    e.limit   = 20'h0FFFF;
    e.gran    = 1'b0;
    e.dpl     = 2'd3;
    e.is_code = 1'b0;
    e.rw_ok   = 1'b1;
    e.rpl     = 2'd0;
    return e;
  endfunction

  function automatic seg_cache_t unpack_desc(input logic [31:0] lo, input logic [31:0] hi,
                                             input logic [1:0] rpl);
    seg_cache_t e;
    e.base    = {hi[31:24], hi[7:0], lo[31:16]};
    e.limit   = {hi[19:16], lo[15:0]};
    e.gran    = hi[23];
    e.dpl     = hi[14:13];
    e.is_code = hi[11];
    e.rw_ok   = hi[9];
    e.rpl     = rpl;
    return e;
  endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] gdt_base_i,
  input  logic [15:0]   gdt_limit_i,
  input  logic [AW-1:0] ldt_base_i,
  input  logic [15:0]   ldt_limit_i,
  output logic [AW-1:0] desc_addr_o,
  output logic [1:0]    rpl_o,
  output logic          idx_ok_o
);
  localparam int IW = SW - 3;

  logic [IW-1:0] idx;
  logic [AW-1:0] tbl_base;
  logic [15:0]   tbl_lim;

  always_comb begin
    idx         = sel_i[SW-1:3];
    tbl_base    = sel_i[2] ? ldt_base_i  : gdt_base_i;
    tbl_lim     = sel_i[2] ? ldt_limit_i : gdt_limit_i;
    rpl_o       = sel_i[1:0];
    desc_addr_o = tbl_base + AW'({idx, 3'b000});
    // whole 8-byte entry must lie inside the table
    idx_ok_o    = {idx, 3'b111} <= tbl_lim;
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] lo_o
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_e;

  fstate_e       state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        F_IDLE: if (start_i) begin
          state_q <= F_LO;
          addr_q  <= addr_i;
        end
        F_LO: if (mem_rvalid_i) begin
          state_q <= F_HI;
          lo_q    <= mem_rdata_i;
          addr_q  <= addr_q + AW'(4);
        end
        F_HI: if (mem_rvalid_i) state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != F_IDLE;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == F_HI) && mem_rvalid_i;
  assign lo_o       = lo_q;
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  seg_cache_t    ent_i,
  input  logic [AW-1:0] offset_i,
  input  logic          write_i,
  output fault_kind_e   kind_o
);
  logic [AW-1:0] eff_lim;
  logic          lim_bad, priv_bad, rights_bad;

  always_comb begin
    eff_lim    = ent_i.gran ? AW'({ent_i.limit, 12'hFFF}) : AW'(ent_i.limit);
    lim_bad    = offset_i > eff_lim;
    priv_bad   = ent_i.rpl > ent_i.dpl;
    rights_bad = write_i ? (ent_i.is_code || !ent_i.rw_ok)
                         : (ent_i.is_code && !ent_i.rw_ok);
    if (lim_bad)         kind_o = FLT_LIMIT;
    else if (priv_bad)   kind_o = FLT_PRIV;
    else if (rights_bad) kind_o = FLT_RIGHTS;
    else                 kind_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  parameter int AW       = 32,
  parameter int SEG_W    = $clog2(NUM_SEGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prot_mode_i,
  input  logic [AW-1:0]    gdt_base_i,
  input  logic [15:0]      gdt_limit_i,
  input  logic [AW-1:0]    ldt_base_i,
  input  logic [15:0]      ldt_limit_i,
  input  logic             ld_valid_i,
  input  logic [SEG_W-1:0] ld_seg_i,
  input  logic [15:0]      ld_value_i,
  input  logic             acc_valid_i,
  input  logic [SEG_W-1:0] acc_seg_i,
  input  logic [AW-1:0]    acc_offset_i,
  input  logic             acc_write_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             busy_o,
  output logic             ld_fault_o,
  output logic             res_valid_o,
  output logic [AW-1:0]    lin_addr_o,
  output logic             fault_o,
  output logic [1:0]       fault_kind_o
);
  logic [AW-1:0]    desc_addr;
  logic [1:0]       sel_rpl;
  logic             idx_ok;
  logic             fetch_busy, fetch_done;
  logic [31:0]      fetch_lo;
  logic             ld_go, acc_go, real_wr, fetch_go;
  logic [SEG_W-1:0] pend_seg_q;
  logic [1:0]       pend_rpl_q;
  seg_cache_t       wr_val;
  seg_cache_t       cache_w [NUM_SEGS];
  seg_cache_t       acc_ent;
  fault_kind_e      acc_kind;

  seg_sel_decode #(.AW(AW), .SW(16)) u_dec (
    .sel_i       (ld_value_i),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .desc_addr_o (desc_addr),
    .rpl_o       (sel_rpl),
    .idx_ok_o    (idx_ok)
  );

  assign ld_go    = ld_valid_i && !fetch_busy;
  assign real_wr  = ld_go && !prot_mode_i;
  assign fetch_go = ld_go && prot_mode_i && idx_ok;
  assign acc_go   = acc_valid_i && !fetch_busy;

  seg_desc_fetch #(.AW(AW), .DW(32)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fetch_go),
    .addr_i       (desc_addr),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .busy_o       (fetch_busy),
    .done_o       (fetch_done),
    .lo_o         (fetch_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_seg_q <= '0;
      pend_rpl_q <= '0;
      ld_fault_o <= 1'b0;
    end else begin
      if (fetch_go) begin
        pend_seg_q <= ld_seg_i;
        pend_rpl_q <= sel_rpl;
      end
      ld_fault_o <= ld_go && prot_mode_i && !idx_ok;
    end
  end

  assign wr_val = real_wr ? real_entry(ld_value_i)
                          : unpack_desc(fetch_lo, mem_rdata_i, pend_rpl_q);

  // hidden descriptor cache, one entry per slot
  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    seg_cache_t entry_q;
    logic       wr_en;
    assign wr_en = (real_wr && ld_seg_i == SEG_W'(s)) ||
                   (fetch_done && pend_seg_q == SEG_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    entry_q <= real_entry(16'h0000);
      else if (wr_en) entry_q <= wr_val;
    end
    assign cache_w[s] = entry_q;
  end

  assign acc_ent = cache_w[acc_seg_i];

  seg_access_check #(.AW(AW)) u_chk_acc (
    .ent_i    (acc_ent),
    .offset_i (acc_offset_i),
    .write_i  (acc_write_i),
    .kind_o   (acc_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      lin_addr_o   <= '0;
      fault_o      <= 1'b0;
      fault_kind_o <= 2'd0;
    end else begin
      res_valid_o  <= acc_go;
      fault_o      <= acc_go && (acc_kind != FLT_NONE);
      fault_kind_o <= acc_go ? acc_kind : FLT_NONE;
      if (acc_go) lin_addr_o <= acc_ent.base + acc_offset_i;
    end
  end

  assign busy_o = fetch_busy;
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ld_valid_i,
  input logic        acc_valid_i,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        busy_o,
  input logic        ld_fault_o,
  input logic        res_valid_o,
  input logic        fault_o
);
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_busy_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !res_valid_o);

  assert_busy_noload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !ld_fault_o);

  assert_ldflt_noread_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fault_o |-> !mem_req_o);

  assert_ldflt_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> !ld_fault_o);

  assert_fault_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> res_valid_o);

  assert_res_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !res_valid_o);
endmodule

bind seg_xlate_unit seg_xlate_checker u_seg_xlate_checker (.*);

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot;
  logic [31:0] gdt_base = 32'h0000_1000, ldt_base = 32'h0000_2000;
  logic [15:0] gdt_lim = 16'h003F, ldt_lim = 16'h000F;
  logic        ld_valid, acc_valid, acc_write;
  logic [1:0]  ld_seg, acc_seg;
  logic [15:0] ld_value;
  logic [31:0] acc_off;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        busy, ld_fault, res_valid, fault;
  logic [31:0] lin_addr;
  logic [1:0]  fault_kind;

  always #5 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .prot_mode_i(prot),
    .gdt_base_i(gdt_base), .gdt_limit_i(gdt_lim),
    .ldt_base_i(ldt_base), .ldt_limit_i(ldt_lim),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_value_i(ld_value),
    .acc_valid_i(acc_valid), .acc_seg_i(acc_seg), .acc_offset_i(acc_off),
    .acc_write_i(acc_write),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .ld_fault_o(ld_fault), .res_valid_o(res_valid),
    .lin_addr_o(lin_addr), .fault_o(fault), .fault_kind_o(fault_kind)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with two cycles of latency per read
  logic [31:0] mem_q [logic [31:0]];
  int          rd_cnt = 0;
  logic [31:0] rd_log [$];
  int          wait_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      wait_cnt   <= 0;
    end else if (mem_req && !mem_rvalid) begin
      if (wait_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_q.exists(mem_addr) ? mem_q[mem_addr] : 32'h0;
        rd_cnt     <= rd_cnt + 1;
        rd_log.push_back(mem_addr);
        wait_cnt   <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else mem_rvalid <= 1'b0;
  end

  // descriptor table model [table][index]
  logic [31:0] tm_base [2][8];
  logic [19:0] tm_lim  [2][8];
  logic        tm_g    [2][8];
  logic [1:0]  tm_dpl  [2][8];
  logic        tm_code [2][8];
  logic        tm_rw   [2][8];

  task automatic put_desc(input int t, input int i, input logic [31:0] b,
                          input logic [19:0] l, input bit g, input logic [1:0] d,
                          input bit code, input bit rw);
    logic [31:0] a, lo, hi;
    a  = (t ? ldt_base : gdt_base) + 32'(i * 8);
    lo = {b[15:0], l[15:0]};
    hi = {b[31:24], g, 3'b100, l[19:16], 1'b1, d, 1'b1, code, 1'b0, rw, 1'b0, b[23:16]};
    mem_q[a] = lo;
    mem_q[a + 32'd4] = hi;
    tm_base[t][i] = b; tm_lim[t][i] = l; tm_g[t][i] = g;
    tm_dpl[t][i] = d; tm_code[t][i] = code; tm_rw[t][i] = rw;
  endtask

  // slot model
  logic [31:0] sm_base [4];
  logic [31:0] sm_lim  [4];
  logic [1:0]  sm_dpl  [4];
  logic [1:0]  sm_rpl  [4];
  logic        sm_code [4];
  logic        sm_rw   [4];

  string       sb_req  [$];
  logic [1:0]  sb_kind [$];
  logic [31:0] sb_lin  [$];

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_req.size() == 0) chk(0, "R12 unexpected result", 32'(res_valid), 32'h0);
      else begin
        string       r;
        logic [1:0]  k;
        logic [31:0] l;
        r = sb_req.pop_front(); k = sb_kind.pop_front(); l = sb_lin.pop_front();
        chk(fault_kind == k && fault == (k != 2'd0), {r, " kind"}, 32'(fault_kind), 32'(k));
        if (k == 2'd0) chk(lin_addr == l, {r, " lin"}, lin_addr, l);
      end
    end
  end

  task automatic do_load(input int s, input logic [15:0] v, input bit exp_flt,
                         input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'(s); ld_value = v;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_fault === exp_flt, {req, " ld_fault"}, 32'(ld_fault), 32'(exp_flt));
    if (prot && !exp_flt) begin
      chk(busy === 1'b1, {req, " busy"}, 32'(busy), 32'h1);
      for (int n = 0; n < 50 && busy; n++) @(negedge clk);
    end
    if (!exp_flt) begin
      if (!prot) begin
        sm_base[s] = {12'b0, v, 4'b0}; sm_lim[s] = 32'hFFFF; sm_dpl[s] = 2'd3;
        sm_rpl[s] = 2'd0; sm_code[s] = 1'b0; sm_rw[s] = 1'b1;
      end else begin
        int t, i;
        t = int'(v[2]); i = int'(v[15:3]);
        sm_base[s] = tm_base[t][i];
        sm_lim[s]  = tm_g[t][i] ? {tm_lim[t][i], 12'hFFF} : {12'b0, tm_lim[t][i]};
        sm_dpl[s]  = tm_dpl[t][i]; sm_rpl[s] = v[1:0];
        sm_code[s] = tm_code[t][i]; sm_rw[s] = tm_rw[t][i];
      end
    end
  endtask

  task automatic do_acc(input int s, input logic [31:0] off, input bit wr,
                        input string req);
    logic [1:0] k;
    if (off > sm_lim[s]) k = 2'd1;
    else if (sm_rpl[s] > sm_dpl[s]) k = 2'd2;
    else if (wr ? (sm_code[s] || !sm_rw[s]) : (sm_code[s] && !sm_rw[s])) k = 2'd3;
    else k = 2'd0;
    sb_req.push_back(req); sb_kind.push_back(k); sb_lin.push_back(sm_base[s] + off);
    @(negedge clk);
    acc_valid = 1'b1; acc_seg = 2'(s); acc_off = off; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    int rc;
    prot = 1'b0; ld_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    ld_seg = '0; acc_seg = '0; ld_value = '0; acc_off = '0;
    for (int s = 0; s < 4; s++) begin
      sm_base[s] = 32'h0; sm_lim[s] = 32'hFFFF; sm_dpl[s] = 2'd3;
      sm_rpl[s] = 2'd0; sm_code[s] = 1'b0; sm_rw[s] = 1'b1;
    end
    put_desc(0, 1, 32'h0010_0000, 20'h000FF, 0, 2'd0, 0, 1);
    put_desc(0, 2, 32'h1000_0000, 20'h001FF, 1, 2'd3, 0, 0);
    put_desc(0, 3, 32'h0000_3000, 20'hFFFFF, 1, 2'd1, 0, 1);
    put_desc(0, 4, 32'h0000_4000, 20'h000FF, 0, 2'd0, 0, 0);
    put_desc(0, 7, 32'h0000_7000, 20'h00010, 0, 2'd0, 0, 1);
    put_desc(1, 0, 32'hFFFF_F000, 20'h01FFF, 0, 2'd3, 1, 1);
    put_desc(1, 1, 32'h0000_5000, 20'h00FFF, 0, 2'd3, 1, 0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(busy === 1'b0 && mem_req === 1'b0, "R6 reset busy", 32'(busy), 32'h0);
    chk(res_valid === 1'b0 && ld_fault === 1'b0, "R12 reset outputs", 32'(res_valid), 32'h0);
    do_acc(0, 32'h1234, 0, "R1 reset slot");

    // real mode
    do_load(1, 16'h0008, 0, "R1 real load");
    do_acc(1, 32'h0010, 0, "R1 real access");
    do_acc(1, 32'hFFFF, 1, "R1 real top");
    do_acc(1, 32'h1_0000, 0, "R2 real limit");

    // protected mode
    prot = 1'b1;
    rc = rd_cnt;
    rd_log.delete();
    do_load(2, 16'h0008, 0, "R3 gdt load");
    chk(rd_cnt - rc == 2, "R5 two reads", 32'(rd_cnt - rc), 32'd2);
    chk(rd_log.size() == 2 && rd_log[0] == 32'h1008, "R3 low addr", rd_log[0], 32'h1008);
    chk(rd_log.size() == 2 && rd_log[1] == 32'h100C, "R3 high addr", rd_log[1], 32'h100C);
    do_acc(2, 32'h00FF, 1, "R7 top of byte limit");
    do_acc(2, 32'h0100, 0, "R7 past byte limit");

    do_load(3, 16'h0013, 0, "R5 granular load");
    do_acc(3, 32'h001F_FFFF, 0, "R7 granular top");
    do_acc(3, 32'h0020_0000, 0, "R7 granular past");
    do_acc(3, 32'h0000_0010, 1, "R9 write read-only data");
    do_acc(3, 32'h0020_0000, 1, "R10 limit over rights");

    do_load(0, 16'h001A, 0, "R8 load rpl2");
    do_acc(0, 32'h0, 0, "R8 rpl above dpl");
    do_load(0, 16'h0019, 0, "R8 load rpl1");
    do_acc(0, 32'h0, 1, "R8 rpl equal dpl");

    do_load(1, 16'h0021, 0, "R10 load");
    do_acc(1, 32'h0, 1, "R10 priv over rights");
    do_acc(1, 32'h100, 1, "R10 limit over priv");

    do_load(2, 16'h0004, 0, "R3 ldt load");
    do_acc(2, 32'h1800, 0, "R11 wrap");
    do_acc(2, 32'h0010, 1, "R9 write code");
    do_load(2, 16'h000C, 0, "R3 ldt index1");
    do_acc(2, 32'h0, 0, "R9 read exec-only");

    // table limit boundaries
    do_load(3, 16'h0038, 0, "R4 last gdt index");
    do_acc(3, 32'h0010, 0, "R4 last index access");
    rc = rd_cnt;
    do_load(3, 16'h0040, 1, "R4 gdt past limit");
    do_load(3, 16'h0014, 1, "R4 ldt past limit");
    repeat (4) @(negedge clk);
    chk(rd_cnt == rc, "R4 no read", 32'(rd_cnt), 32'(rc));
    do_acc(3, 32'h0011, 0, "R4 slot unchanged");

    // accesses never read memory
    rc = rd_cnt;
    do_acc(3, 32'h0, 0, "R11 acc a");
    do_acc(2, 32'h0, 0, "R11 acc b");
    repeat (4) @(negedge clk);
    chk(rd_cnt == rc, "R11 no access reads", 32'(rd_cnt), 32'(rc));

    // requests during busy are dropped
    rc = rd_cnt;
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'd1; ld_value = 16'h0008;
    @(negedge clk);
    ld_seg = 2'd0; ld_value = 16'h0040;
    acc_valid = 1'b1; acc_seg = 2'd0; acc_off = 32'h0; acc_write = 1'b0;
    @(negedge clk);
    chk(ld_fault === 1'b0, "R6 busy load dropped", 32'(ld_fault), 32'h0);
    @(negedge clk);
    ld_valid = 1'b0; acc_valid = 1'b0;
    for (int n = 0; n < 50 && busy; n++) @(negedge clk);
    chk(rd_cnt - rc == 2, "R6 one fetch only", 32'(rd_cnt - rc), 32'd2);
    sm_base[1] = 32'h0010_0000; sm_lim[1] = 32'hFF; sm_dpl[1] = 2'd0;
    sm_rpl[1] = 2'd0; sm_code[1] = 1'b0; sm_rw[1] = 1'b1;
    do_acc(1, 32'h0040, 1, "R6 first load landed");
    do_acc(0, 32'h0020, 1, "R6 slot0 untouched");

    repeat (3) @(negedge clk);
    chk(sb_req.size() == 0, "R12 missing results", 32'(sb_req.size()), 32'h0);
    summary();
    $finish;
  end
endmodule